// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling software. It holds one free-running cycle counter and a small bank of programmable event counters, all 32 bits wide. Each event counter is given a 7-bit event code; in every clock cycle the code picks one line out of a wide vector of event pulses, and the counter advances when that line is high. The cycle counter can be slowed by a divide-by-64 prescaler and can be frozen while the core is halted for debugging.

Software drives the unit through a plain word-addressed register port. Counter enables and interrupt enables are changed through separate set and clear addresses, so one counter can be turned on or off without a read-modify-write. Event counters are reached through a select register that steers an event-code window and a count window. When a counter wraps past its top value, its overflow flag is set. The flag stays set until software writes a one to it. A single interrupt line merges every flag whose interrupt enable is on.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, every counter, the control register, both enable masks, the overflow flags and the select register are zero, and `irq` is low.
- R2: Register offsets on `reg_addr` are: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow flags, 6 select, 7 event code, 8 event count, 9 cycle count. `reg_rdata` shows the register at the address that was present on the previous clock edge.
- R3: The enable, interrupt-enable and overflow registers use one layout: bits 0..3 are event counters 0..3 and bit 31 is the cycle counter. All other bits are ignored on write and read as 0. On a set address a 1 turns the bit on. On a clear address a 1 turns it off. A 0 leaves the bit unchanged. Both addresses of a pair read back the current mask.
- R4: An event counter adds one on each clock where control bit 0 (global enable) is set, its own enable bit is set, and `evt_in[code]` is high. Otherwise it holds its value.
- R5: When enabled, the cycle counter adds one every clock. With control bit 3 set, it adds one on each 64th enabled clock instead.
- R6: A wrap from 0xFFFFFFFF to 0 sets that counter's overflow flag. Writing a 1 to a flag bit clears it. If the clear and a wrap land on the same clock, the flag ends up clear.
- R7: `irq` is high one clock after any overflow flag is set while its interrupt enable is set. It falls one clock after no such pair remains.
- R8: Writing control bit 1 clears all event counters together. Writing control bit 2 clears the cycle counter and its prescaler. Both bits read back as 0, and bits 0, 3, 4 and 5 read back as written.
- R9: The select register keeps 5 bits. The event-code window (7 bits) and the event-count window act on the event counter that is selected. A select value of 4 or more makes both windows read 0 and ignore writes.
- R10: Writing a count address loads that counter. A load on the same clock as a counted event gives the written value.
- R11: With control bit 5 set and `dbg_halt` high, the cycle counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | 128 | Event pulse vector, indexed by event code |
| dbg_halt | input | 1 | Core is halted for debugging |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A wrong enable, event code or prescaler state appears as a count that is off by an exact amount. This is visible at the first read of the count window once a pulse train of known length has ended. Flag and interrupt faults appear on `irq` one clock after the wrap, and in the overflow readback. The tests that need the most care are the same-clock collisions: a load against an event, a clear against a wrap, and the prescaler boundary on the 64th enabled clock. Each of these ends in a value that is off by one if the priority or the wrap point is wrong.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] ADR_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] ADR_EN_SET  = 4'd1;
  localparam logic [REG_AW-1:0] ADR_EN_CLR  = 4'd2;
  localparam logic [REG_AW-1:0] ADR_IE_SET  = 4'd3;
  localparam logic [REG_AW-1:0] ADR_IE_CLR  = 4'd4;
  localparam logic [REG_AW-1:0] ADR_OVF     = 4'd5;
  localparam logic [REG_AW-1:0] ADR_SEL     = 4'd6;
  localparam logic [REG_AW-1:0] ADR_EVCODE  = 4'd7;
  localparam logic [REG_AW-1:0] ADR_EVCOUNT = 4'd8;
  localparam logic [REG_AW-1:0] ADR_CYCOUNT = 4'd9;

  localparam int CB_RUN     = 0;
  localparam int CB_EVT_RST = 1;
  localparam int CB_CYC_RST = 2;
  localparam int CB_DIV     = 3;
  localparam int CB_EXPORT  = 4;
  localparam int CB_DBGSTOP = 5;
  localparam int CTRL_W     = 6;

  localparam int MASK_CYC_POS = 31;
endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
  parameter int CNT_W  = 32,
  parameter int CODE_W = 7,
  localparam int SRC_N = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic [SRC_N-1:0]  evt_vec,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              clear,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              bump;

  assign bump   = count_en && evt_vec[code_q];
  assign wrap_o = bump && !load_en && !clear && (cnt_q == '1);
  assign code_o = code_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (code_we) code_q <= code_wdata;
      if (load_en)     cnt_q <= load_val;
      else if (clear)  cnt_q <= '0;
      else if (bump)   cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_EVT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !clear && !count_en) |=> $stable(cnt_q)); // R4
  AST_EVT_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cnt_q == $past(load_val))); // R10
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clear && !load_en) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 64,
  localparam int PS_W    = $clog2(PRESCALE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run && (!div_en || ps_q == PS_LAST);
  assign wrap_o = tick && !load_en && !clear && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ps_q <= '0;
    end else if (run && div_en) begin
      ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load_en)   cnt_q <= load_val;
    else if (clear)     cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  AST_CYC_PRESCALE_GATE: assert property (@(posedge clk) disable iff (rst)
    (div_en && ps_q != PS_LAST && !load_en && !clear) |=> $stable(cnt_q)); // R5
  AST_CYC_HALTED: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en && !clear) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 4,
  parameter int CODE_W   = 7,
  parameter int SEL_W    = 5,
  parameter int PRESCALE = 64,
  localparam int SRC_N   = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [SRC_N-1:0]  evt_in,
  input  logic              dbg_halt,
  output logic              irq
);
  localparam int MASK_W = NUM_EVT + 1;
  localparam int CYC    = NUM_EVT;
  localparam int IDX_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [MASK_W-1:0] en_q, ie_q, ovf_q, wrap;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_ok;
  logic [IDX_W-1:0]  sel_idx;
  logic [MASK_W-1:0] wmask;
  logic [CNT_W-1:0]  evt_cnt [NUM_EVT];
  logic [CODE_W-1:0] evt_code [NUM_EVT];
  logic [CNT_W-1:0]  cyc_cnt;
  logic              wr_ctrl, wr_ovf, evt_clear, cyc_clear;

  function automatic logic [REG_DW-1:0] spread(input logic [MASK_W-1:0] m);
    logic [REG_DW-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_EVT; k++) v[k] = m[k];
    v[MASK_CYC_POS] = m[CYC];
    return v;
  endfunction

  assign wmask     = {reg_wdata[MASK_CYC_POS], reg_wdata[NUM_EVT-1:0]};
  assign sel_ok    = (sel_q < SEL_W'(NUM_EVT));
  assign sel_idx   = sel_q[IDX_W-1:0];
  assign wr_ctrl   = reg_we && reg_addr == ADR_CTRL;
  assign wr_ovf    = reg_we && reg_addr == ADR_OVF;
  assign evt_clear = wr_ctrl && reg_wdata[CB_EVT_RST];
  assign cyc_clear = wr_ctrl && reg_wdata[CB_CYC_RST];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic hit;
    assign hit = sel_ok && sel_idx == IDX_W'(g);
    pmu_event_ctr #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .count_en  (ctrl_q[CB_RUN] && en_q[g]),
      .evt_vec   (evt_in),
      .code_we   (reg_we && reg_addr == ADR_EVCODE && hit),
      .code_wdata(reg_wdata[CODE_W-1:0]),
      .load_en   (reg_we && reg_addr == ADR_EVCOUNT && hit),
      .load_val  (reg_wdata[CNT_W-1:0]),
      .clear     (evt_clear),
      .code_o    (evt_code[g]),
      .cnt_o     (evt_cnt[g]),
      .wrap_o    (wrap[g])
    );
  end

  pmu_cycle_ctr #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[CB_RUN] && en_q[CYC] && !(ctrl_q[CB_DBGSTOP] && dbg_halt)),
    .div_en  (ctrl_q[CB_DIV]),
    .load_en (reg_we && reg_addr == ADR_CYCOUNT),
    .load_val(reg_wdata[CNT_W-1:0]),
    .clear   (cyc_clear),
    .cnt_o   (cyc_cnt),
    .wrap_o  (wrap[CYC])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= reg_wdata[CTRL_W-1:0];
        ctrl_q[CB_EVT_RST] <= 1'b0;
        ctrl_q[CB_CYC_RST] <= 1'b0;
      end
      if (reg_we && reg_addr == ADR_EN_SET) en_q <= en_q | wmask;
      if (reg_we && reg_addr == ADR_EN_CLR) en_q <= en_q & ~wmask;
      if (reg_we && reg_addr == ADR_IE_SET) ie_q <= ie_q | wmask;
      if (reg_we && reg_addr == ADR_IE_CLR) ie_q <= ie_q & ~wmask;
      if (reg_we && reg_addr == ADR_SEL)    sel_q <= reg_wdata[SEL_W-1:0];
      ovf_q <= (ovf_q | wrap) & ~(wr_ovf ? wmask : '0);
      irq   <= |(ovf_q & ie_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        ADR_CTRL:                reg_rdata[CTRL_W-1:0] <= ctrl_q;
        ADR_EN_SET, ADR_EN_CLR:  reg_rdata <= spread(en_q);
        ADR_IE_SET, ADR_IE_CLR:  reg_rdata <= spread(ie_q);
        ADR_OVF:                 reg_rdata <= spread(ovf_q);
        ADR_SEL:                 reg_rdata[SEL_W-1:0] <= sel_q;
        ADR_EVCODE:  if (sel_ok) reg_rdata[CODE_W-1:0] <= evt_code[sel_idx];
        ADR_EVCOUNT: if (sel_ok) reg_rdata[CNT_W-1:0] <= evt_cnt[sel_idx];
        ADR_CYCOUNT:             reg_rdata[CNT_W-1:0] <= cyc_cnt;
        default:                 reg_rdata <= '0;
      endcase
    end
  end

  AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
    |(ovf_q & ~$past(ovf_q)) |-> |$past(wrap)); // R6
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_ovf && reg_wdata[0]) |=> !ovf_q[0]); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(ovf_q & ie_q))); // R7
  AST_RESET_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_EVT_RST] == 1'b0) && (ctrl_q[CB_CYC_RST] == 1'b0)); // R8
endmodule

// File: tb/test_pmu_counter_unit.sv
module test_pmu_counter_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_IES = 4'd3,
                         A_IEC = 4'd4, A_OVF = 4'd5, A_SEL = 4'd6, A_CODE = 4'd7,
                         A_CNT = 4'd8, A_CYC = 4'd9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [127:0] evt_in = '0;
  logic        dbg_halt = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_counter_unit i_pmu_counter_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .dbg_halt(dbg_halt), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int bitn, input int n);
    evt_in[bitn] = 1'b1;
    idle(n);
    evt_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); check("R1", "control", v, 32'h0);
    rd(A_ENS, v);  check("R1", "enable mask", v, 32'h0);
    rd(A_IES, v);  check("R1", "irq enable mask", v, 32'h0);
    rd(A_OVF, v);  check("R1", "flags", v, 32'h0);
    rd(A_CYC, v);  check("R1", "cycle count", v, 32'h0);
    rd(A_CNT, v);  check("R1", "event count 0", v, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R8", "control readback drops reset bits", v, 32'h39);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check("R2", "control cleared", v, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(A_ENS, 32'hFFFF_FFFF);
    rd(A_ENS, v); check("R3", "set keeps bits 0-3 and 31", v, 32'h8000_000F);
    wr(A_ENC, 32'h8000_0001);
    rd(A_ENC, v); check("R3", "clear address reads mask", v, 32'h0000_000E);
    wr(A_ENS, 32'h0);
    rd(A_ENS, v); check("R3", "zero set bits no effect", v, 32'h0000_000E);
    wr(A_ENC, 32'hFFFF_FFFF);
    wr(A_IES, 32'h8000_0004);
    rd(A_IEC, v); check("R3", "irq enable mask", v, 32'h8000_0004);
    wr(A_IEC, 32'hFFFF_FFFF);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(A_SEL, 0); wr(A_CODE, 3);
    wr(A_SEL, 1); wr(A_CODE, 5);
    wr(A_SEL, 2); wr(A_CODE, 3);
    wr(A_SEL, 3); wr(A_CODE, 32'hFF);
    rd(A_CODE, v); check("R9", "event code 7 bits", v, 32'h7F);
    wr(A_ENS, 32'h3);
    wr(A_CTRL, 32'h1);
    pulse(5, 4);
    pulse(3, 7);
    wr(A_SEL, 1); rd(A_CNT, v); check("R4", "counter 1 code 5", v, 32'd4);
    wr(A_SEL, 0); rd(A_CNT, v); check("R4", "counter 0 code 3", v, 32'd7);
    wr(A_SEL, 2); rd(A_CNT, v); check("R4", "disabled counter 2 holds", v, 32'd0);
    wr(A_CTRL, 32'h0);
    pulse(3, 5);
    wr(A_SEL, 0); rd(A_CNT, v); check("R4", "global enable off holds", v, 32'd7);
    wr(A_CTRL, 32'h3);
    rd(A_CNT, v); check("R8", "event reset clears counter 0", v, 32'd0);
    wr(A_SEL, 1); rd(A_CNT, v); check("R8", "event reset clears counter 1", v, 32'd0);
    rd(A_CTRL, v); check("R8", "reset bit reads 0", v, 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(A_SEL, 0);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_IES, 32'h1);
    check("R7", "irq low before wrap", {31'b0, irq}, 32'h0);
    pulse(3, 3);
    idle(1);
    check("R7", "irq after wrap", {31'b0, irq}, 32'h1);
    rd(A_OVF, v); check("R6", "flag set on wrap", v, 32'h1);
    rd(A_CNT, v); check("R6", "count after wrap", v, 32'd1);
    wr(A_OVF, 32'h1);
    idle(1);
    check("R7", "irq after clear", {31'b0, irq}, 32'h0);
    rd(A_OVF, v); check("R6", "flag cleared by one", v, 32'h0);
    wr(A_IEC, 32'h1);
    wr(A_CNT, 32'hFFFF_FFFF);
    pulse(3, 1);
    idle(2);
    check("R7", "masked flag keeps irq low", {31'b0, irq}, 32'h0);
    rd(A_OVF, v); check("R6", "flag set while masked", v, 32'h1);
    wr(A_IES, 32'h1);
    idle(2);
    check("R7", "irq after late enable", {31'b0, irq}, 32'h1);
    wr(A_OVF, 32'h1);
    wr(A_IEC, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear_priority();
    logic [31:0] v;
    wr(A_CNT, 32'hFFFF_FFFF);
    evt_in[3] = 1'b1;
    wr(A_OVF, 32'h1);
    evt_in = '0;
    rd(A_OVF, v); check("R6", "clear beats same-cycle wrap", v, 32'h0);
    rd(A_CNT, v); check("R6", "counter wrapped to zero", v, 32'h0);
  endtask

  task automatic t_load_priority();
    logic [31:0] v;
    evt_in[3] = 1'b1;
    wr(A_CNT, 32'd100);
    evt_in = '0;
    rd(A_CNT, v); check("R10", "load beats same-cycle event", v, 32'd100);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr(A_SEL, 32'hFF);
    rd(A_SEL, v); check("R9", "select keeps 5 bits", v, 32'h1F);
    wr(A_SEL, 5);
    wr(A_CNT, 32'd1234);
    wr(A_CODE, 32'd1);
    rd(A_CNT, v);  check("R9", "out-of-range count reads 0", v, 32'h0);
    rd(A_CODE, v); check("R9", "out-of-range code reads 0", v, 32'h0);
    wr(A_SEL, 0);
    rd(A_CNT, v);  check("R9", "counter 0 untouched", v, 32'd100);
    rd(A_CODE, v); check("R9", "code 0 untouched", v, 32'd3);
    wr(A_CTRL, 32'h0);
    wr(A_ENC, 32'hFFFF_FFFF);
  endtask

  task automatic t_cycle();
    logic [31:0] v;
    wr(A_ENS, 32'h8000_0000);
    wr(A_CYC, 32'h0);
    wr(A_CTRL, 32'h1);
    idle(19);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); check("R5", "cycle count 20 clocks", v, 32'd20);
    wr(A_CYC, 32'd500);
    rd(A_CYC, v); check("R10", "cycle preload", v, 32'd500);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(A_CTRL, 32'h4);
    rd(A_CYC, v); check("R8", "cycle reset", v, 32'd0);
    wr(A_CTRL, 32'h9);
    idle(190);
    wr(A_CTRL, 32'h8);
    rd(A_CYC, v); check("R5", "191 clocks divided", v, 32'd2);
    wr(A_CTRL, 32'h9);
    wr(A_CTRL, 32'h8);
    rd(A_CYC, v); check("R5", "192nd clock ticks", v, 32'd3);
    wr(A_CTRL, 32'h4);
  endtask

  task automatic t_debug();
    logic [31:0] v;
    dbg_halt = 1'b1;
    wr(A_CTRL, 32'h21);
    idle(10);
    wr(A_CTRL, 32'h20);
    rd(A_CYC, v); check("R11", "halted cycle counter", v, 32'd0);
    dbg_halt = 1'b0;
    wr(A_CTRL, 32'h21);
    idle(4);
    wr(A_CTRL, 32'h20);
    rd(A_CYC, v); check("R11", "runs after halt released", v, 32'd5);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_masks();
    t_events();
    t_overflow();
    t_clear_priority();
    t_load_priority();
    t_select();
    t_cycle();
    t_prescale();
    t_debug();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule